// File: doc/BRIEF.md
# Framed Command Receiver with Checksum

This block parses a byte stream arriving over a host link. It hunts for a fixed three-byte sync signature (D5, AA, 96). It then collects the six body bytes that follow: a command code, a 16-bit address, a 16-bit length and a check byte. A command is issued only when the check byte matches the XOR of the seed 81 with the code, address and length bytes, and the code is one the block knows. A rejected frame raises an error pulse, and the block goes back to hunting.

Two commands carry a data phase. For a download, the host sends the announced number of bytes on the same stream, and the receiver counts them. For an upload, the data mover sends the bytes to the host and signals each one on a done strobe, and the receiver counts those strobes. While the data phase lasts, the block does not parse incoming bytes as framing. The page-set command also has its address split into a page number and a bank number for the memory mapper. Moving memory data and executing jumps are the job of other blocks.

Top module: `cmdRx`

## Requirements
- R1: While reset is held, and in the cycle after it is released, cmdValid, errChecksum, errCode, xferActive and xferEnd are all low.
- R2: A frame is D5, AA, 96, code, address low, address high, length low, length high, check. When the ninth byte is accepted with a good check and a known code, cmdValid is high for exactly the one cycle after that byte's clock edge. In that cycle cmdCode, cmdAddr and cmdLen carry the received fields, and they hold until the next issued command.
- R3: A byte that breaks the sync signature restarts the hunt. If that byte is D5, it counts as the first signature byte (for example D5 D5 AA 96, or D5 AA D5 AA 96, still frames a command).
- R4: The check byte must equal 81 XOR code XOR address low XOR address high XOR length low XOR length high. On a mismatch, errChecksum pulses for one cycle in place of cmdValid, and the hunt restarts.
- R5: The known codes are 00 (download), 01 (upload), 04 (jump), 05 (page set) and 06 (sub-function). With a good check and any other code, errCode pulses in place of cmdValid. When both the check and the code are bad, only errChecksum pulses. At most one of cmdValid, errChecksum and errCode is high in any cycle.
- R6: Code 00 with a nonzero length raises xferActive in the same cycle as cmdValid, with xferToHost low. The next `length` bytes with inValid high are counted as data and never parsed as framing.
- R7: Code 01 with a nonzero length raises xferActive with xferToHost high. Only moverDone pulses are counted, and inValid bytes are ignored until the phase ends.
- R8: xferEnd is high for the one cycle after the edge that takes the final counted event, and xferActive is low in that same cycle. A sync byte presented in that very cycle is accepted as the start of a new frame.
- R9: Code 00 or 01 with a length of zero issues cmdValid and never raises xferActive.
- R10: pageNum equals cmdAddr bits 1..0, and bankNum equals cmdAddr bits 9..2 (address low bits 7..2 below address high bits 1..0).
- R11: Bytes are taken only in cycles where inValid is high. moverDone has no effect outside an upload phase.
- R12: Codes 04, 05 and 06 never start a data phase, whatever their length field holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | inData holds a byte this cycle |
| inData | input | 8 | Incoming stream byte |
| moverDone | input | 1 | Data mover finished sending one byte to the host |
| cmdValid | output | 1 | One-cycle pulse: a command was accepted |
| cmdCode | output | 8 | Code of the last accepted command |
| cmdAddr | output | 16 | Address of the last accepted command |
| cmdLen | output | 16 | Length of the last accepted command |
| pageNum | output | 2 | Page number field of cmdAddr |
| bankNum | output | 8 | Bank number field of cmdAddr |
| errChecksum | output | 1 | One-cycle pulse: check byte mismatch |
| errCode | output | 1 | One-cycle pulse: unknown command code |
| xferActive | output | 1 | Data phase in progress |
| xferToHost | output | 1 | Current data phase is an upload |
| xferEnd | output | 1 | One-cycle pulse: data phase finished |

## Verification
The end of a data phase and the start of a new sync hunt share one clock edge. The edge that counts the final data byte or done strobe also re-arms the signature matcher. The bench provokes this by presenting D5 in the cycle right after the last counted event, and then finishing a frame. It judges the result by requiring xferEnd with xferActive low at that boundary, followed by a correctly decoded cmdValid nine bytes later. The bench also feeds the signature bytes themselves as download data, which confirms that data-phase bytes never reach the framing logic.

// File: rtl/cmdRxPkg.sv
package cmdRxPkg;
  localparam logic [7:0] SYNC_B0   = 8'hD5;
  localparam logic [7:0] SYNC_B1   = 8'hAA;
  localparam logic [7:0] SYNC_B2   = 8'h96;
  localparam logic [7:0] CSUM_SEED = 8'h81;

  localparam logic [7:0] OP_DOWNLOAD = 8'h00;
  localparam logic [7:0] OP_UPLOAD   = 8'h01;
  localparam logic [7:0] OP_JUMP     = 8'h04;
  localparam logic [7:0] OP_PAGE     = 8'h05;
  localparam logic [7:0] OP_SUB      = 8'h06;

  // body = code, addrLo, addrHi, lenLo, lenHi, check
  localparam int BODY_BYTES = 6;

  typedef enum logic [2:0] {
    ST_HUNT0, ST_HUNT1, ST_HUNT2, ST_BODY, ST_XFER
  } rxState_e;

  typedef struct packed {
    logic clrBody;
    logic capByte;
    logic issue;
    logic errSum;
    logic errCode;
    logic loadCount;
    logic decCount;
    logic endXfer;
  } rxStrobe_t;

  typedef struct packed {
    logic bodyLast;
    logic csumOk;
    logic codeOk;
    logic dataCmd;
    logic lenZero;
    logic toHost;
    logic countOne;
  } rxStatus_t;
endpackage

// File: rtl/cmdRxData.sv
module cmdRxData
  import cmdRxPkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       inData,
  input  rxStrobe_t        stb,
  output rxStatus_t        stat,
  output logic             cmdValid,
  output logic [7:0]       cmdCode,
  output logic [15:0]      cmdAddr,
  output logic [LEN_W-1:0] cmdLen,
  output logic             errChecksum,
  output logic             errCode
);
  localparam int IDX_W  = $clog2(BODY_BYTES + 1);
  localparam int SLOT_N = BODY_BYTES - 1;

  logic [7:0]       bodyReg [SLOT_N];
  logic [IDX_W-1:0] bodyIdx;
  logic [7:0]       csumAcc;
  logic [LEN_W-1:0] xferCnt;
  logic             toHostReg;
  logic [LEN_W-1:0] rxLen;

  assign rxLen = LEN_W'({bodyReg[4], bodyReg[3]});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bodyIdx <= '0;
      csumAcc <= CSUM_SEED;
      for (int i = 0; i < SLOT_N; i++) bodyReg[i] <= '0;
    end else if (stb.clrBody) begin
      bodyIdx <= '0;
      csumAcc <= CSUM_SEED;
    end else if (stb.capByte) begin
      bodyIdx <= bodyIdx + 1'b1;
      if (!stat.bodyLast) csumAcc <= csumAcc ^ inData;
      for (int i = 0; i < SLOT_N; i++)
        if (bodyIdx == IDX_W'(i)) bodyReg[i] <= inData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid    <= 1'b0;
      errChecksum <= 1'b0;
      errCode     <= 1'b0;
      cmdCode     <= '0;
      cmdAddr     <= '0;
      cmdLen      <= '0;
      toHostReg   <= 1'b0;
      xferCnt     <= '0;
    end else begin
      cmdValid    <= stb.issue;
      errChecksum <= stb.errSum;
      errCode     <= stb.errCode;
      if (stb.issue) begin
        cmdCode   <= bodyReg[0];
        cmdAddr   <= {bodyReg[2], bodyReg[1]};
        cmdLen    <= rxLen;
        toHostReg <= (bodyReg[0] == OP_UPLOAD);
      end
      if (stb.loadCount)     xferCnt <= rxLen;
      else if (stb.decCount) xferCnt <= xferCnt - 1'b1;
    end
  end

  always_comb begin
    stat          = '0;
    stat.bodyLast = (bodyIdx == IDX_W'(BODY_BYTES - 1));
    stat.csumOk   = (inData == csumAcc);
    stat.codeOk   = (bodyReg[0] == OP_DOWNLOAD) || (bodyReg[0] == OP_UPLOAD) ||
                    (bodyReg[0] == OP_JUMP) || (bodyReg[0] == OP_PAGE) ||
                    (bodyReg[0] == OP_SUB);
    stat.dataCmd  = (bodyReg[0] == OP_DOWNLOAD) || (bodyReg[0] == OP_UPLOAD);
    stat.lenZero  = (rxLen == '0);
    stat.toHost   = toHostReg;
    stat.countOne = (xferCnt == LEN_W'(1));
  end

  // R6: the data counter is never decremented from zero
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.decCount |-> (xferCnt != '0));

  // R5: one outcome per frame at most
  p_single_outcome_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdValid, errChecksum, errCode}));
endmodule

// File: rtl/cmdRxCtrl.sv
module cmdRxCtrl
  import cmdRxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inData,
  input  logic       moverDone,
  input  rxStatus_t  stat,
  output rxStrobe_t  stb,
  output logic       xferActive,
  output logic       xferEnd
);
  rxState_e state, nxt;
  logic     xferEvent;

  assign xferEvent = stat.toHost ? moverDone : inValid;

  always_comb begin
    nxt = state;
    stb = '0;
    unique case (state)
      ST_HUNT0: if (inValid && inData == SYNC_B0) nxt = ST_HUNT1;
      ST_HUNT1: if (inValid) begin
        if (inData == SYNC_B1)      nxt = ST_HUNT2;
        else if (inData == SYNC_B0) nxt = ST_HUNT1;
        else                        nxt = ST_HUNT0;
      end
      ST_HUNT2: if (inValid) begin
        if (inData == SYNC_B2) begin
          nxt         = ST_BODY;
          stb.clrBody = 1'b1;
        end else if (inData == SYNC_B0) nxt = ST_HUNT1;
        else                            nxt = ST_HUNT0;
      end
      ST_BODY: if (inValid) begin
        stb.capByte = 1'b1;
        if (stat.bodyLast) begin
          nxt = ST_HUNT0;
          if (!stat.csumOk)      stb.errSum  = 1'b1;
          else if (!stat.codeOk) stb.errCode = 1'b1;
          else begin
            stb.issue = 1'b1;
            if (stat.dataCmd && !stat.lenZero) begin
              stb.loadCount = 1'b1;
              nxt           = ST_XFER;
            end
          end
        end
      end
      ST_XFER: if (xferEvent) begin
        stb.decCount = 1'b1;
        if (stat.countOne) begin
          stb.endXfer = 1'b1;
          nxt         = ST_HUNT0;
        end
      end
      default: nxt = ST_HUNT0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_HUNT0;
      xferEnd <= 1'b0;
    end else begin
      state   <= nxt;
      xferEnd <= stb.endXfer;
    end
  end

  assign xferActive = (state == ST_XFER);

  // R4: a rejected frame sends the parser back to the hunt
  p_hunt_after_reject_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.errSum || stb.errCode) |=> (state == ST_HUNT0));
endmodule

// File: rtl/cmdRx.sv
module cmdRx
  import cmdRxPkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [7:0]       inData,
  input  logic             moverDone,
  output logic             cmdValid,
  output logic [7:0]       cmdCode,
  output logic [15:0]      cmdAddr,
  output logic [LEN_W-1:0] cmdLen,
  output logic [1:0]       pageNum,
  output logic [7:0]       bankNum,
  output logic             errChecksum,
  output logic             errCode,
  output logic             xferActive,
  output logic             xferToHost,
  output logic             xferEnd
);
  rxStrobe_t stb;
  rxStatus_t stat;

  cmdRxCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .moverDone(moverDone), .stat(stat), .stb(stb),
    .xferActive(xferActive), .xferEnd(xferEnd)
  );

  cmdRxData #(.LEN_W(LEN_W)) u_data (
    .clk(clk), .rstN(rstN), .inData(inData), .stb(stb), .stat(stat),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdAddr(cmdAddr),
    .cmdLen(cmdLen), .errChecksum(errChecksum), .errCode(errCode)
  );

  assign pageNum    = cmdAddr[1:0];
  assign bankNum    = cmdAddr[9:2];
  assign xferToHost = xferActive & stat.toHost;

  // R6: a data phase only opens together with an issued command
  p_xfer_with_cmd_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferActive) |-> cmdValid);

  // R8: the end pulse coincides with the phase closing
  p_end_on_close_r8: assert property (@(posedge clk) disable iff (!rstN)
    xferEnd |-> (!xferActive && $past(xferActive)));

  // R2: a command is issued only on an accepted byte
  p_valid_needs_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $past(inValid));
endmodule

// File: tb/cmdRx_tb.sv
module cmdRx_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = 8'h00;
  logic        moverDone = 1'b0;
  logic        cmdValid, errChecksum, errCode, xferActive, xferToHost, xferEnd;
  logic [7:0]  cmdCode, bankNum;
  logic [15:0] cmdAddr, cmdLen;
  logic [1:0]  pageNum;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  cmdRx u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .moverDone(moverDone), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdAddr(cmdAddr), .cmdLen(cmdLen), .pageNum(pageNum), .bankNum(bankNum),
    .errChecksum(errChecksum), .errCode(errCode), .xferActive(xferActive),
    .xferToHost(xferToHost), .xferEnd(xferEnd)
  );

  // {code, addr, len, corruptCheck, kind}: kind 0 issue, 1 check error, 2 code error
  localparam logic [42:0] VEC [8] = '{
    {8'h04, 16'h1234, 16'h0005, 1'b0, 2'd0},
    {8'h05, 16'h02F7, 16'h0000, 1'b0, 2'd0},
    {8'h06, 16'h0002, 16'h0009, 1'b0, 2'd0},
    {8'h00, 16'hABCD, 16'h0000, 1'b0, 2'd0},
    {8'h02, 16'h0000, 16'h0001, 1'b0, 2'd2},
    {8'h01, 16'h0010, 16'h0004, 1'b1, 2'd1},
    {8'h07, 16'h0000, 16'h0000, 1'b1, 2'd1},
    {8'h01, 16'h5555, 16'h0000, 1'b0, 2'd0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic putByte(input logic [7:0] b);
    inValid = 1'b1; inData = b; moverDone = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle();
    inValid = 1'b0; inData = 8'hD5; moverDone = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseDone();
    inValid = 1'b0; moverDone = 1'b1;
    @(negedge clk);
  endtask

  task automatic sendCmd(input logic [7:0] code, input logic [15:0] addr,
                         input logic [15:0] len, input bit bad, input bit gaps);
    logic [7:0] sum;
    sum = 8'h81 ^ code ^ addr[7:0] ^ addr[15:8] ^ len[7:0] ^ len[15:8];
    if (bad) sum = ~sum;
    putByte(8'hD5); if (gaps) idle();
    putByte(8'hAA); if (gaps) idle();
    putByte(8'h96); if (gaps) idle();
    putByte(code);  if (gaps) idle();
    putByte(addr[7:0]); if (gaps) idle();
    putByte(addr[15:8]); if (gaps) idle();
    putByte(len[7:0]); if (gaps) idle();
    putByte(len[15:8]); if (gaps) idle();
    putByte(sum);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!cmdValid && !errChecksum && !errCode && !xferActive && !xferEnd,
        "R1 in reset", {cmdValid, errChecksum, errCode, xferActive, xferEnd}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!cmdValid && !errChecksum && !errCode && !xferActive && !xferEnd,
        "R1 after reset", {cmdValid, errChecksum, errCode, xferActive, xferEnd}, 0);

    // vector table
    for (int i = 0; i < 8; i++) begin
      logic [7:0] vc; logic [15:0] va, vl; logic vb; logic [1:0] vk;
      {vc, va, vl, vb, vk} = VEC[i];
      sendCmd(vc, va, vl, vb, 1'b0);
      if (vk == 2'd0) begin
        chk(cmdValid && !errChecksum && !errCode, "R2 issue", cmdValid, 1);
        chk(cmdCode == vc && cmdAddr == va && cmdLen == vl, "R2 fields",
            {cmdCode, cmdAddr}, {vc, va});
        chk(!xferActive, "R9 R12 no data phase", xferActive, 0);
        if (vc == 8'h05)
          chk(pageNum == 2'd3 && bankNum == 8'hBD, "R10 page/bank",
              {pageNum, bankNum}, {2'd3, 8'hBD});
      end else if (vk == 2'd1) begin
        chk(errChecksum && !errCode && !cmdValid, "R4 R5 check error",
            {cmdValid, errChecksum, errCode}, 3'b010);
      end else begin
        chk(errCode && !errChecksum && !cmdValid, "R5 code error",
            {cmdValid, errChecksum, errCode}, 3'b001);
      end
      idle();
      chk(!cmdValid && !errChecksum && !errCode, "R2 one-cycle pulse",
          {cmdValid, errChecksum, errCode}, 0);
    end

    // download of 3 bytes whose values look like a signature
    sendCmd(8'h00, 16'h0100, 16'd3, 1'b0, 1'b0);
    chk(cmdValid && xferActive && !xferToHost, "R6 download opens",
        {cmdValid, xferActive, xferToHost}, 3'b110);
    pulseDone();
    chk(xferActive, "R11 done ignored in download", xferActive, 1);
    putByte(8'hD5);
    putByte(8'hAA);
    chk(xferActive && !xferEnd, "R6 counting", {xferActive, xferEnd}, 2'b10);
    putByte(8'h96);
    chk(xferEnd && !xferActive && !cmdValid, "R6 R8 download closes",
        {xferEnd, xferActive, cmdValid}, 3'b100);
    idle();
    chk(!xferEnd, "R8 end one cycle", xferEnd, 0);

    // upload of 2 with stray stream bytes, then back-to-back frame
    sendCmd(8'h01, 16'h0200, 16'd2, 1'b0, 1'b0);
    chk(cmdValid && xferActive && xferToHost, "R7 upload opens",
        {cmdValid, xferActive, xferToHost}, 3'b111);
    putByte(8'h00); putByte(8'h11); putByte(8'h22);
    chk(xferActive, "R7 stream bytes ignored", xferActive, 1);
    pulseDone();
    chk(xferActive && !xferEnd, "R7 first done", {xferActive, xferEnd}, 2'b10);
    pulseDone();
    chk(xferEnd && !xferActive, "R7 R8 upload closes", {xferEnd, xferActive}, 2'b10);
    sendCmd(8'h04, 16'hBEEF, 16'h0000, 1'b0, 1'b0);
    chk(cmdValid && cmdAddr == 16'hBEEF, "R8 back-to-back frame", cmdAddr, 16'hBEEF);

    // signature recovery
    putByte(8'hD5);
    sendCmd(8'h04, 16'h0101, 16'h0000, 1'b0, 1'b0);
    chk(cmdValid && cmdAddr == 16'h0101, "R3 D5 D5 AA 96", cmdAddr, 16'h0101);
    putByte(8'hD5); putByte(8'hAA);
    sendCmd(8'h04, 16'h0202, 16'h0000, 1'b0, 1'b0);
    chk(cmdValid && cmdAddr == 16'h0202, "R3 D5 AA D5 AA 96", cmdAddr, 16'h0202);
    putByte(8'hD5); putByte(8'hAA); putByte(8'h00); putByte(8'h96);
    putByte(8'h04); putByte(8'h00); putByte(8'h00); putByte(8'h00);
    putByte(8'h00); putByte(8'h85);
    chk(!cmdValid && !errChecksum && !errCode, "R3 broken signature",
        {cmdValid, errChecksum, errCode}, 0);

    // gaps with invalid D5 bytes between frame bytes
    sendCmd(8'h05, 16'h0007, 16'h0000, 1'b0, 1'b1);
    chk(cmdValid && cmdAddr == 16'h0007 && pageNum == 2'd3 && bankNum == 8'h01,
        "R11 R10 gapped frame", cmdAddr, 16'h0007);
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule